// File: doc/BRIEF.md
# SDRAM Bring-up and Refresh Sequencer

This block sits on the controller side of a single-data-rate SDRAM interface. After reset it drives the memory through its power-up routine. It holds the command bus idle for a stabilization interval, closes every bank, and issues a configurable number of auto refreshes. It then programs the normal mode register and, last of all, the extended mode register, which carries the partial-array refresh and drive-strength settings. After a short lockout it raises a ready flag.

Once ready, the block becomes a refresh scheduler. A free-running interval timer adds one owed refresh to a backlog each time the average refresh interval elapses. While the backlog is non-empty and no row-cycle spacing is in progress, it raises a request. The surrounding controller answers with a grant once it has all banks precharged. The block then drives the refresh command on the next cycle. If grants are withheld, the owed refreshes pile up to a fixed limit and are later issued back to back, with row-cycle spacing between them.

All timing is given in picoseconds and converted to clock counts at elaboration. Minimum spacings are rounded up. The average interval is rounded down.

Top module: `sdram_boot_refresh`

## Requirements
- R1: While rst_n is low the command output is NOP, with encoding {cs_n,ras_n,cas_n,we_n} = 4'b0111. Address and bank are zero, and ready and ref_req are low.
- R2: After reset is released, the command stays NOP for STARTUP_CYC = ceil(STARTUP_PS/CLK_PS) cycles. The first other command is precharge-all (4'b0010 with address bit 10 set, bank 0). It appears on the outputs after the STARTUP_CYC-th rising edge.
- R3: INIT_REFS auto refreshes (4'b0001, address and bank zero) follow the precharge. The first comes ceil(TRP_PS/CLK_PS) cycles after the precharge. Each later one comes ceil(TRC_PS/CLK_PS) cycles after the previous refresh.
- R4: The normal mode register write (4'b0000, bank 0, address MODE_WORD) comes ceil(TRC_PS/CLK_PS) cycles after the last start-up refresh. The extended mode register write (4'b0000, bank 2'b10, address EXT_WORD) follows exactly MRD_CYC cycles later.
- R5: ready rises exactly MRD_CYC cycles after the extended mode register write, with only NOP in between. It then stays high until the next reset.
- R6: Starting when ready rises, one refresh becomes owed every REFI_CYC = floor(REFI_PS/CLK_PS) cycles. The first is owed REFI_CYC cycles after ready rises.
- R7: ref_req is high exactly when ready is high, at least one refresh is owed, and no row-cycle spacing is running. ref_gnt has no effect while ref_req is low, including before ready.
- R8: A cycle with ref_req and ref_gnt both high produces a refresh command on the next cycle and removes one owed refresh. No further command is issued for the following TRC_CYC-1 cycles.
- R9: At most MAX_PEND refreshes can be owed. Intervals that elapse while the backlog is full are dropped, so a withheld grant is followed by a burst of exactly MAX_PEND refreshes spaced TRC_CYC apart.
- R10: Once ready is high, the only commands driven are auto refresh and NOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_gnt_i | input | 1 | Grant: all banks precharged, refresh may go out |
| cmd_o | output | 4 | Command {cs_n,ras_n,cas_n,we_n} |
| addr_o | output | ADDR_W | Address bus (13) |
| bank_o | output | BANK_W | Bank select (2) |
| ready_o | output | 1 | Bring-up complete |
| ref_req_o | output | 1 | Refresh slot requested |

## Verification
The bench builds the block with a 10 ns clock, a 200 ns stabilization time, three start-up refreshes, non-default mode words and an 800 ns refresh interval. These values give spacings of 2, 7 and 80 cycles, and the whole bring-up finishes in under fifty cycles. The short interval lets the grant be withheld across ten intervals within about a thousand cycles. That exposes backlog saturation at eight, the back-to-back burst at row-cycle spacing, and the timer keeping its phase through the burst. The rounding paths are also exercised: 67.5 ns rounds up to 7 cycles and 18 ns rounds up to 2.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } sdr_cmd_e;

    // Each state names the command issued when its wait counter is zero.
    typedef enum logic [2:0] {
        ST_POWERUP,
        ST_AREF,
        ST_MODE,
        ST_EXTMODE,
        ST_LOCK,
        ST_RUN
    } seq_st_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/sdram_refi_timer.sv
module sdram_refi_timer #(
    parameter int REFI_CYC = 1041
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int CW = (REFI_CYC > 2) ? $clog2(REFI_CYC) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(REFI_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (!en_i) begin
            s_d.cnt = RELOAD;
        end else if (s_q.cnt == '0) begin
            s_d.cnt = RELOAD;
        end else begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    assign tick_o = en_i && (s_q.cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.cnt <= RELOAD;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/sdram_ref_backlog.sv
module sdram_ref_backlog #(
    parameter int MAX_PEND = 8,
    localparam int PW      = $clog2(MAX_PEND + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          take_i,
    output logic [PW-1:0] pend_o,
    output logic          any_o
);
    localparam logic [PW-1:0] LIMIT = PW'(MAX_PEND);

    typedef struct packed {
        logic [PW-1:0] pend;
    } blg_t;

    blg_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        unique case ({tick_i, take_i})
            2'b10: if (s_q.pend != LIMIT) s_d.pend = s_q.pend + 1'b1;
            2'b01: if (s_q.pend != '0)    s_d.pend = s_q.pend - 1'b1;
            default: s_d.pend = s_q.pend;
        endcase
    end

    assign pend_o = s_q.pend;
    assign any_o  = (s_q.pend != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.pend <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/sdram_boot_refresh.sv
module sdram_boot_refresh
    import sdram_seq_pkg::*;
#(
    parameter int CLK_PS     = 7500,
    parameter int STARTUP_PS = 200_000_000,
    parameter int TRP_PS     = 18_000,
    parameter int TRC_PS     = 67_500,
    parameter int REFI_PS    = 7_812_500,
    parameter int INIT_REFS  = 2,
    parameter int MRD_CYC    = 2,
    parameter int MAX_PEND   = 8,
    parameter int ADDR_W     = 13,
    parameter int BANK_W     = 2,
    parameter logic [ADDR_W-1:0] MODE_WORD = 'h032,
    parameter logic [ADDR_W-1:0] EXT_WORD  = 'h000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_gnt_i,
    output logic [3:0]        cmd_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [BANK_W-1:0] bank_o,
    output logic              ready_o,
    output logic              ref_req_o
);
    localparam int STARTUP_CYC = ceil_div(STARTUP_PS, CLK_PS);
    localparam int TRP_CYC     = ceil_div(TRP_PS, CLK_PS);
    localparam int TRC_CYC     = ceil_div(TRC_PS, CLK_PS);
    localparam int REFI_CYC    = REFI_PS / CLK_PS;
    localparam int WAIT_W      = $clog2(STARTUP_CYC + TRC_CYC + MRD_CYC + 1);
    localparam int REFS_W      = $clog2(INIT_REFS + 1);
    localparam int PEND_W      = $clog2(MAX_PEND + 1);
    localparam int AP_BIT      = 10;
    localparam logic [BANK_W-1:0] EXT_BANK = BANK_W'(2);

    typedef struct packed {
        seq_st_e            st;
        logic [WAIT_W-1:0]  wait_cnt;
        logic [REFS_W-1:0]  refs;
        sdr_cmd_e           cmd;
        logic [ADDR_W-1:0]  addr;
        logic [BANK_W-1:0]  bank;
        logic               ready;
    } seq_t;

    seq_t s_q, s_d;

    logic              tick;
    logic              take;
    logic              owed;
    logic [PEND_W-1:0] pend;
    logic [WAIT_W-1:0] wait_dn;

    sdram_refi_timer #(.REFI_CYC(REFI_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (s_q.ready),
        .tick_o (tick)
    );

    sdram_ref_backlog #(.MAX_PEND(MAX_PEND)) u_backlog (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .take_i (take),
        .pend_o (pend),
        .any_o  (owed)
    );

    assign wait_dn   = s_q.wait_cnt - 1'b1;
    assign ref_req_o = s_q.ready && owed && (s_q.wait_cnt == '0);

    always_comb begin
        s_d      = s_q;
        s_d.cmd  = CMD_NOP;
        s_d.addr = '0;
        s_d.bank = '0;
        take     = 1'b0;
        if (s_q.wait_cnt != '0) begin
            s_d.wait_cnt = wait_dn;
        end else begin
            unique case (s_q.st)
                ST_POWERUP: begin
                    s_d.cmd          = CMD_PRE;
                    s_d.addr[AP_BIT] = 1'b1;
                    s_d.wait_cnt     = WAIT_W'(TRP_CYC - 1);
                    s_d.st           = ST_AREF;
                end
                ST_AREF: begin
                    s_d.cmd      = CMD_REF;
                    s_d.wait_cnt = WAIT_W'(TRC_CYC - 1);
                    if (s_q.refs == REFS_W'(INIT_REFS - 1)) begin
                        s_d.refs = '0;
                        s_d.st   = ST_MODE;
                    end else begin
                        s_d.refs = s_q.refs + 1'b1;
                    end
                end
                ST_MODE: begin
                    s_d.cmd      = CMD_MRS;
                    s_d.addr     = MODE_WORD;
                    s_d.wait_cnt = WAIT_W'(MRD_CYC - 1);
                    s_d.st       = ST_EXTMODE;
                end
                ST_EXTMODE: begin
                    s_d.cmd      = CMD_MRS;
                    s_d.addr     = EXT_WORD;
                    s_d.bank     = EXT_BANK;
                    s_d.wait_cnt = WAIT_W'(MRD_CYC - 1);
                    s_d.st       = ST_LOCK;
                end
                ST_LOCK: begin
                    s_d.ready = 1'b1;
                    s_d.st    = ST_RUN;
                end
                ST_RUN: begin
                    if (owed && ref_gnt_i) begin
                        s_d.cmd      = CMD_REF;
                        s_d.wait_cnt = WAIT_W'(TRC_CYC - 1);
                        take         = 1'b1;
                    end
                end
                default: s_d.st = ST_POWERUP;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st       <= ST_POWERUP;
            s_q.wait_cnt <= WAIT_W'(STARTUP_CYC - 1);
            s_q.refs     <= '0;
            s_q.cmd      <= CMD_NOP;
            s_q.addr     <= '0;
            s_q.bank     <= '0;
            s_q.ready    <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cmd_o   = s_q.cmd;
    assign addr_o  = s_q.addr;
    assign bank_o  = s_q.bank;
    assign ready_o = s_q.ready;

    logic unused_pend;
    assign unused_pend = ^pend;
endmodule

// File: rtl/sdram_boot_refresh_chk.sv
module sdram_boot_refresh_chk #(
    parameter int ADDR_W = 13,
    parameter int BANK_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ref_gnt_i,
    input logic [3:0]        cmd_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic [BANK_W-1:0] bank_o,
    input logic              ready_o,
    input logic              ref_req_o
);
    // R5
    ready_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> ready_o);

    // R5
    ready_after_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> ($past(cmd_o, 2) == 4'b0000 && $past(bank_o, 2) == BANK_W'(2)));

    // R7
    req_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req_o |-> ready_o);

    // R8
    grant_issues_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req_o && ref_gnt_i) |=> (cmd_o == 4'b0001));

    // R8
    spacing_after_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && cmd_o == 4'b0001) |-> !ref_req_o);

    // R4
    mode_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 4'b0000) |=> (cmd_o == 4'b0111));

    // R10
    run_cmds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (cmd_o == 4'b0111 || cmd_o == 4'b0001));

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!rst_n && $past(!rst_n)) |-> (cmd_o == 4'b0111 && !ready_o));

    logic unused_addr;
    assign unused_addr = ^addr_o;
endmodule

bind sdram_boot_refresh sdram_boot_refresh_chk #(
    .ADDR_W (ADDR_W),
    .BANK_W (BANK_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_gnt_i (ref_gnt_i),
    .cmd_o     (cmd_o),
    .addr_o    (addr_o),
    .bank_o    (bank_o),
    .ready_o   (ready_o),
    .ref_req_o (ref_req_o)
);

// File: tb/sim_sdram_boot_refresh.sv
`timescale 1ns/1ps
module sim_sdram_boot_refresh;
    localparam int TCLK    = 10;
    localparam int P_CLK   = 10_000;
    localparam int P_STUP  = 200_000;
    localparam int P_TRP   = 18_000;
    localparam int P_TRC   = 67_500;
    localparam int P_REFI  = 800_000;
    localparam int N_INIT  = 3;
    localparam int MRD     = 2;
    localparam logic [12:0] MODE_W = 13'h022;
    localparam logic [12:0] EXT_W  = 13'h021;

    localparam int C_STUP = (P_STUP + P_CLK - 1) / P_CLK;
    localparam int C_TRP  = (P_TRP + P_CLK - 1) / P_CLK;
    localparam int C_TRC  = (P_TRC + P_CLK - 1) / P_CLK;
    localparam int C_REFI = P_REFI / P_CLK;

    localparam int E_PRE  = C_STUP;
    localparam int E_R1   = E_PRE + C_TRP;
    localparam int E_R2   = E_R1 + C_TRC;
    localparam int E_R3   = E_R2 + C_TRC;
    localparam int E_MRS  = E_R3 + C_TRC;
    localparam int E_EMRS = E_MRS + MRD;
    localparam int E_RDY  = E_EMRS + MRD;
    localparam int E_F1   = E_RDY + C_REFI + 1;
    localparam int E_F2   = E_F1 + C_REFI;
    localparam int REL    = 1010;
    localparam int E_B    = REL + 1;
    localparam int E_NX   = E_RDY + ((REL - E_RDY) / C_REFI + 1) * C_REFI + 1;
    localparam int END_C  = E_NX + 30;

    localparam logic [3:0] K_NOP = 4'b0111;
    localparam logic [3:0] K_REF = 4'b0001;
    localparam logic [3:0] K_PRE = 4'b0010;
    localparam logic [3:0] K_MRS = 4'b0000;

    typedef struct packed {
        logic [31:0] cyc;
        logic [3:0]  cmd;
        logic [1:0]  bank;
        logic [12:0] addr;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{32'(E_PRE),  K_PRE, 2'b00, 13'h400},
        '{32'(E_R1),   K_REF, 2'b00, 13'h000},
        '{32'(E_R2),   K_REF, 2'b00, 13'h000},
        '{32'(E_R3),   K_REF, 2'b00, 13'h000},
        '{32'(E_MRS),  K_MRS, 2'b00, MODE_W},
        '{32'(E_EMRS), K_MRS, 2'b10, EXT_W},
        '{32'(E_F1),   K_REF, 2'b00, 13'h000},
        '{32'(E_F2),   K_REF, 2'b00, 13'h000},
        '{32'(E_B + 0*C_TRC), K_REF, 2'b00, 13'h000},
        '{32'(E_B + 1*C_TRC), K_REF, 2'b00, 13'h000},
        '{32'(E_B + 2*C_TRC), K_REF, 2'b00, 13'h000},
        '{32'(E_B + 3*C_TRC), K_REF, 2'b00, 13'h000},
        '{32'(E_B + 4*C_TRC), K_REF, 2'b00, 13'h000},
        '{32'(E_B + 5*C_TRC), K_REF, 2'b00, 13'h000},
        '{32'(E_B + 6*C_TRC), K_REF, 2'b00, 13'h000},
        '{32'(E_B + 7*C_TRC), K_REF, 2'b00, 13'h000},
        '{32'(E_NX),   K_REF, 2'b00, 13'h000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_gnt = 1'b1;
    logic [3:0]  cmd;
    logic [12:0] addr;
    logic [1:0]  bank;
    logic        ready;
    logic        ref_req;

    int cyc = 0;
    int total = 0;
    int bad = 0;
    int n_log = 0;
    bit done = 1'b0;
    int          log_cyc  [32];
    logic [3:0]  log_cmd  [32];
    logic [1:0]  log_bank [32];
    logic [12:0] log_addr [32];

    always #(TCLK/2) clk = ~clk;

    sdram_boot_refresh #(
        .CLK_PS(P_CLK), .STARTUP_PS(P_STUP), .TRP_PS(P_TRP), .TRC_PS(P_TRC),
        .REFI_PS(P_REFI), .INIT_REFS(N_INIT), .MRD_CYC(MRD), .MAX_PEND(8),
        .ADDR_W(13), .BANK_W(2), .MODE_WORD(MODE_W), .EXT_WORD(EXT_W)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .ref_gnt_i(ref_gnt),
        .cmd_o(cmd), .addr_o(addr), .bank_o(bank),
        .ready_o(ready), .ref_req_o(ref_req)
    );

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && cmd != K_NOP && n_log < 32) begin
            log_cyc[n_log]  <= cyc;
            log_cmd[n_log]  <= cmd;
            log_bank[n_log] <= bank;
            log_addr[n_log] <= addr;
            n_log <= n_log + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic wait_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 cmd", 32'(cmd), 32'(K_NOP));
        check("R1 addr/bank", 32'({bank, addr}), 32'h0);
        check("R1 ready", 32'(ready), 0);
        check("R1 ref_req", 32'(ref_req), 0);
        rst_n = 1'b1;

        wait_cyc(30);
        // R7 grant held high before ready has no effect
        check("R7 req before ready", 32'(ref_req), 0);
        wait_cyc(E_RDY - 1);
        check("R5 ready low before lockout ends", 32'(ready), 0);
        wait_cyc(E_RDY);
        check("R5 ready rises", 32'(ready), 1);
        wait_cyc(E_F1 - 1);
        // R6 first owed refresh after one interval
        check("R6 req after interval", 32'(ref_req), 1);
        wait_cyc(E_F1);
        check("R8 req drops after grant", 32'(ref_req), 0);
        wait_cyc(E_F2);
        ref_gnt = 1'b0;
        wait_cyc(500);
        check("R7 req held while withheld", 32'(ref_req), 1);
        wait_cyc(REL);
        ref_gnt = 1'b1;
        wait_cyc(E_B + 1);
        check("R8 req low during spacing", 32'(ref_req), 0);
        wait_cyc(END_C);

        // R2 R3 R4 R6 R8 R9 R10 command log against the vector table
        check("R9 command count", 32'(n_log), 32'(NV));
        for (int i = 0; i < NV; i++) begin
            if (i < n_log) begin
                check(i < 6 ? "R2/R3/R4 time" : "R6/R8/R9 time",
                      32'(log_cyc[i]), VEC[i].cyc);
                check(i < 6 ? "R2/R3/R4 cmd" : "R10 cmd",
                      32'(log_cmd[i]), 32'(VEC[i].cmd));
                check(i < 6 ? "R2/R3/R4 addr" : "R10 addr",
                      32'({log_bank[i], log_addr[i]}), 32'({VEC[i].bank, VEC[i].addr}));
            end
        end
        check("R5 ready stays", 32'(ready), 1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule